// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns the operand fields of an already decoded instruction into a memory address. It keeps four 16-bit segment registers. For each request it forms a 16-bit effective address (offset) from the base register, index register and displacement that the operand mode selects. It then picks a segment register from the access class, the base register and an optional override, and adds the segment value shifted left by four bits to the offset. The result is a 20-bit physical address.

Requests are sampled on a rising clock edge when `req_valid` is high. The effective address and the physical address are registered, so they appear one cycle later with `out_valid`. When no request is presented, both outputs keep their last values. The segment registers are loaded through a simple write port. A load and a request on the same edge give the request the old segment value.

Top module: `seg_addr_gen`

## Requirements
- R1: For every accepted request, `pa_out` equals (segment << 4) + `ea_out`, truncated to 20 bits. Both outputs and `out_valid` are updated on the clock edge after the edge that sampled `req_valid` high. `out_valid` is low after an edge where `req_valid` was low.
- R2: For data accesses, `mode` selects the offset, with all sums wrapping modulo 2^16. The codes are: 0 = displacement; 1 = base; 2 = index; 3 = base + displacement; 4 = index + displacement; 5 = base + index + displacement; 6 and 7 = displacement. The base is BX when `base_sel` is 0 and BP when it is 1. The index is SI when `idx_sel` is 0 and DI when it is 1.
- R3: When `disp_wide` is 1, the displacement is all 16 bits of `disp`. When it is 0, the displacement is `disp[7:0]` sign-extended to 16 bits, and `disp[15:8]` has no effect.
- R4: An access of class 1 (instruction fetch) uses CS as the segment and `reg_ip` as the offset.
- R5: An access of class 2 (stack) uses SS as the segment and `reg_sp` as the offset.
- R6: An access of class 3 (string destination) uses ES as the segment and `reg_di` as the offset.
- R7: An access of class 0 (data) with no override uses SS when the mode includes a base (codes 1, 3, 5) and `base_sel` is 1 (BP). In every other case it uses DS.
- R8: When `ovr_en` is 1, `ovr_seg` replaces the default segment for data accesses. For access classes 1, 2 and 3 the override has no effect.
- R9: Segment number encoding, shared by `seg_sel` and `ovr_seg`: 0 = ES, 1 = CS, 2 = SS, 3 = DS. A load with `seg_we` high takes effect for requests sampled on later edges. A request on the same edge uses the previous value.
- R10: During reset, `ea_out`, `pa_out`, `out_valid` and all segment registers are zero. When `req_valid` is low, `ea_out` and `pa_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seg_we | input | 1 | Segment register load enable |
| seg_sel | input | 2 | Segment register to load (0 ES, 1 CS, 2 SS, 3 DS) |
| seg_wdata | input | 16 | Value to load |
| req_valid | input | 1 | Address request present |
| acc | input | 2 | Access class: 0 data, 1 fetch, 2 stack, 3 string destination |
| mode | input | 3 | Operand mode for data accesses |
| disp_wide | input | 1 | 1 = full 16-bit displacement, 0 = sign-extended low byte |
| base_sel | input | 1 | Base register: 0 BX, 1 BP |
| idx_sel | input | 1 | Index register: 0 SI, 1 DI |
| disp | input | 16 | Displacement |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment number |
| reg_ip | input | 16 | Instruction pointer value |
| reg_sp | input | 16 | Stack pointer value |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| ea_out | output | 16 | Registered effective address |
| pa_out | output | 20 | Registered physical address |
| out_valid | output | 1 | Outputs belong to a request sampled on the previous edge |

## Verification
Both address outputs and `out_valid` are due exactly one edge after the request is sampled. A segment load is seen only by requests sampled on later edges.

The bench drives stimulus on the falling edge. Its model computes the expected result from the inputs present at the rising edge, using the model's segment values from before that edge's load. It then compares on the next falling edge, so every comparison covers one register stage. Idle cycles keep the previous expectation, which checks the hold behaviour on every clock.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int OFS_W       = 16;
  localparam int SEG_SHIFT   = 4;
  localparam int PA_W        = OFS_W + SEG_SHIFT;
  localparam int NSEG        = 4;
  localparam int SEL_W       = $clog2(NSEG);
  localparam int DISP_NARROW = 8;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_DATA  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_STACK = 2'd2,
    ACC_SDST  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    MD_DISP      = 3'd0,
    MD_BASE      = 3'd1,
    MD_INDEX     = 3'd2,
    MD_BASE_D    = 3'd3,
    MD_INDEX_D   = 3'd4,
    MD_BASE_IX_D = 3'd5,
    MD_RSV6      = 3'd6,
    MD_RSV7      = 3'd7
  } mode_e;

  function automatic logic mode_uses_base(input mode_e m);
    return (m == MD_BASE) || (m == MD_BASE_D) || (m == MD_BASE_IX_D);
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int W  = OFS_W,
  parameter int N  = NSEG,
  parameter int SW = SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SW-1:0]       sel,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] segs
);
  for (genvar g = 0; g < N; g++) begin : g_seg
    logic         load_en;
    logic [W-1:0] seg_q;

    always_comb load_en = we && (sel == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seg_q <= '0;
      else if (load_en) seg_q <= wdata;
    end

    assign segs[g] = seg_q;
  end
endmodule

// File: rtl/seg_ea_calc.sv
module seg_ea_calc
  import seg_pkg::*;
#(
  parameter int W  = OFS_W,
  parameter int DN = DISP_NARROW
) (
  input  acc_e         acc,
  input  mode_e        mode,
  input  logic         disp_wide,
  input  logic         base_sel,
  input  logic         idx_sel,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] reg_ip,
  input  logic [W-1:0] reg_sp,
  input  logic [W-1:0] reg_bx,
  input  logic [W-1:0] reg_bp,
  input  logic [W-1:0] reg_si,
  input  logic [W-1:0] reg_di,
  output logic [W-1:0] ea
);
  logic [W-1:0] disp_ext;
  logic [W-1:0] base_v;
  logic [W-1:0] idx_v;
  logic [W-1:0] data_ea;

  always_comb begin
    disp_ext = disp_wide ? disp : {{(W-DN){disp[DN-1]}}, disp[DN-1:0]};
    base_v   = base_sel ? reg_bp : reg_bx;
    idx_v    = idx_sel  ? reg_di : reg_si;
  end

  always_comb begin
    unique case (mode)
      MD_BASE:      data_ea = base_v;
      MD_INDEX:     data_ea = idx_v;
      MD_BASE_D:    data_ea = base_v + disp_ext;
      MD_INDEX_D:   data_ea = idx_v + disp_ext;
      MD_BASE_IX_D: data_ea = base_v + idx_v + disp_ext;
      default:      data_ea = disp_ext;
    endcase
  end

  always_comb begin
    unique case (acc)
      ACC_FETCH: ea = reg_ip;
      ACC_STACK: ea = reg_sp;
      ACC_SDST:  ea = reg_di;
      default:   ea = data_ea;
    endcase
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
(
  input  acc_e    acc,
  input  mode_e   mode,
  input  logic    base_sel,
  input  logic    ovr_en,
  input  seg_id_e ovr_seg,
  output seg_id_e seg_id
);
  seg_id_e data_default;

  always_comb begin
    data_default = (mode_uses_base(mode) && base_sel) ? SEG_SS : SEG_DS;
    unique case (acc)
      ACC_FETCH: seg_id = SEG_CS;
      ACC_STACK: seg_id = SEG_SS;
      ACC_SDST:  seg_id = SEG_ES;
      default:   seg_id = ovr_en ? ovr_seg : data_default;
    endcase
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seg_we,
  input  logic [1:0]  seg_sel,
  input  logic [15:0] seg_wdata,
  input  logic        req_valid,
  input  logic [1:0]  acc,
  input  logic [2:0]  mode,
  input  logic        disp_wide,
  input  logic        base_sel,
  input  logic        idx_sel,
  input  logic [15:0] disp,
  input  logic        ovr_en,
  input  logic [1:0]  ovr_seg,
  input  logic [15:0] reg_ip,
  input  logic [15:0] reg_sp,
  input  logic [15:0] reg_bx,
  input  logic [15:0] reg_bp,
  input  logic [15:0] reg_si,
  input  logic [15:0] reg_di,
  output logic [15:0] ea_out,
  output logic [19:0] pa_out,
  output logic        out_valid
);
  logic [NSEG-1:0][OFS_W-1:0] segs;
  logic [OFS_W-1:0]           ea_nxt;
  logic [PA_W-1:0]            pa_nxt;
  logic [OFS_W-1:0]           seg_val;
  seg_id_e                    seg_id;

  logic [OFS_W-1:0] ea_q;
  logic [PA_W-1:0]  pa_q;
  logic             vld_q;

  seg_regfile #(.W(OFS_W), .N(NSEG), .SW(SEL_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (seg_we),
    .sel   (seg_sel),
    .wdata (seg_wdata),
    .segs  (segs)
  );

  seg_ea_calc #(.W(OFS_W), .DN(DISP_NARROW)) u_ea (
    .acc       (acc_e'(acc)),
    .mode      (mode_e'(mode)),
    .disp_wide (disp_wide),
    .base_sel  (base_sel),
    .idx_sel   (idx_sel),
    .disp      (disp),
    .reg_ip    (reg_ip),
    .reg_sp    (reg_sp),
    .reg_bx    (reg_bx),
    .reg_bp    (reg_bp),
    .reg_si    (reg_si),
    .reg_di    (reg_di),
    .ea        (ea_nxt)
  );

  seg_select u_sel (
    .acc      (acc_e'(acc)),
    .mode     (mode_e'(mode)),
    .base_sel (base_sel),
    .ovr_en   (ovr_en),
    .ovr_seg  (seg_id_e'(ovr_seg)),
    .seg_id   (seg_id)
  );

  always_comb begin
    seg_val = segs[seg_id];
    pa_nxt  = {seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_nxt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= '0;
      pa_q <= '0;
    end else if (req_valid) begin
      ea_q <= ea_nxt;
      pa_q <= pa_nxt;
    end
  end

  assign ea_out    = ea_q;
  assign pa_out    = pa_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        seg_we,
  input logic [1:0]  seg_sel,
  input logic [15:0] seg_wdata,
  input logic        req_valid,
  input logic [1:0]  acc,
  input logic [15:0] reg_ip,
  input logic [15:0] reg_sp,
  input logic [15:0] reg_di,
  input logic [15:0] ea_out,
  input logic [19:0] pa_out,
  input logic        out_valid
);
  logic [15:0] sh_es, sh_cs, sh_ss;
  logic [19:0] pa_fetch, pa_stack, pa_sdst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_es <= '0;
      sh_cs <= '0;
      sh_ss <= '0;
    end else if (seg_we) begin
      if (seg_sel == 2'd0) sh_es <= seg_wdata;
      if (seg_sel == 2'd1) sh_cs <= seg_wdata;
      if (seg_sel == 2'd2) sh_ss <= seg_wdata;
    end
  end

  always_comb begin
    pa_fetch = {sh_cs, 4'h0} + {4'h0, reg_ip};
    pa_stack = {sh_ss, 4'h0} + {4'h0, reg_sp};
    pa_sdst  = {sh_es, 4'h0} + {4'h0, reg_di};
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R1
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R1
  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pa_out[3:0] == ea_out[3:0])); // R1
  AST_FETCH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc == 2'd1) |=> (pa_out == $past(pa_fetch) && ea_out == $past(reg_ip))); // R4
  AST_STACK_SS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc == 2'd2) |=> (pa_out == $past(pa_stack) && ea_out == $past(reg_sp))); // R5
  AST_SDST_ES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc == 2'd3) |=> (pa_out == $past(pa_sdst) && ea_out == $past(reg_di))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(ea_out) && $stable(pa_out))); // R10
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (.*);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_we;
  logic [1:0]  seg_sel;
  logic [15:0] seg_wdata;
  logic        req_valid;
  logic [1:0]  acc;
  logic [2:0]  mode;
  logic        disp_wide, base_sel, idx_sel, ovr_en;
  logic [15:0] disp;
  logic [1:0]  ovr_seg;
  logic [15:0] reg_ip, reg_sp, reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] ea_out;
  logic [19:0] pa_out;
  logic        out_valid;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int m_seg [4];
  int exp_ea = 0, exp_pa = 0;
  bit exp_v = 0;

  always #4 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (.*);

  function automatic int ref_ea();
    int d, b, x, r;
    d = disp_wide ? int'(disp) : ((disp[7] ? 32'hFF00 : 0) | int'(disp[7:0]));
    b = base_sel ? int'(reg_bp) : int'(reg_bx);
    x = idx_sel ? int'(reg_di) : int'(reg_si);
    case (acc)
      2'd1: r = reg_ip;
      2'd2: r = reg_sp;
      2'd3: r = reg_di;
      default:
        case (mode)
          3'd1: r = b;
          3'd2: r = x;
          3'd3: r = b + d;
          3'd4: r = x + d;
          3'd5: r = b + x + d;
          default: r = d;
        endcase
    endcase
    return r % 65536;
  endfunction

  function automatic int ref_seg();
    bit has_base;
    has_base = (mode == 3'd1) || (mode == 3'd3) || (mode == 3'd5);
    case (acc)
      2'd1: return 1;
      2'd2: return 2;
      2'd3: return 0;
      default: return ovr_en ? int'(ovr_seg) : ((has_base && base_sel) ? 2 : 3);
    endcase
  endfunction

  task automatic check(input string tag);
    tests++;
    if (out_valid !== exp_v || int'(ea_out) != exp_ea || int'(pa_out) != exp_pa) begin
      fails++;
      $display("FAIL %s: got v=%0b ea=%h pa=%h, expected v=%0b ea=%h pa=%h",
               tag, out_valid, ea_out, pa_out, exp_v, exp_ea[15:0], exp_pa[19:0]);
    end
  endtask

  task automatic go(input string tag);
    int e;
    @(posedge clk);
    exp_v = req_valid;
    if (req_valid) begin
      e      = ref_ea();
      exp_ea = e;
      exp_pa = (m_seg[ref_seg()] * 16 + e) % (1 << 20);
    end
    if (seg_we) m_seg[seg_sel] = seg_wdata;
    @(negedge clk);
    check(tag);
    seg_we = 0;
    req_valid = 0;
  endtask

  task automatic load_seg(input int s, input int v, input string tag);
    seg_we = 1; seg_sel = 2'(s); seg_wdata = 16'(v);
    go(tag);
  endtask

  task automatic req(input int a, input int md, input bit w, input bit bs, input bit xs,
                     input int d, input bit oe, input int os, input string tag);
    req_valid = 1; acc = 2'(a); mode = 3'(md); disp_wide = w; base_sel = bs;
    idx_sel = xs; disp = 16'(d); ovr_en = oe; ovr_seg = 2'(os);
    go(tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    if (!done) $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_seg[i] = 0;
    rst_n = 0; seg_we = 0; seg_sel = 0; seg_wdata = 0; req_valid = 0; acc = 0;
    mode = 0; disp_wide = 0; base_sel = 0; idx_sel = 0; disp = 0; ovr_en = 0;
    ovr_seg = 0; reg_ip = 16'h0100; reg_sp = 16'hFFFE; reg_bx = 16'h1000;
    reg_bp = 16'h2000; reg_si = 16'h0020; reg_di = 16'h0040;
    repeat (3) @(negedge clk);
    check("R10 reset");
    rst_n = 1;
    @(negedge clk);
    check("R10 after reset");

    load_seg(0, 16'h5000, "R9 load ES");
    load_seg(1, 16'h1234, "R9 load CS");
    load_seg(2, 16'h2100, "R9 load SS");
    load_seg(3, 16'h3000, "R9 load DS");

    req(1, 0, 0, 0, 0, 0, 0, 0, "R4 fetch");
    req(1, 0, 0, 0, 0, 0, 1, 3, "R8 fetch ignores override");
    req(2, 0, 0, 0, 0, 0, 0, 0, "R5 stack");
    req(2, 0, 0, 0, 0, 0, 1, 0, "R8 stack ignores override");
    req(3, 0, 0, 0, 0, 0, 0, 0, "R6 string dest");
    req(3, 0, 0, 0, 0, 0, 1, 3, "R6 string dest ignores override");
    req(0, 0, 1, 0, 0, 16'h1875, 0, 0, "R2 direct wide");
    req(0, 3, 0, 0, 0, 16'hAB04, 0, 0, "R3 based BX narrow +4");
    req(0, 3, 0, 1, 0, 16'h00FC, 0, 0, "R7 based BP narrow -4 uses SS");
    req(0, 3, 1, 1, 0, 16'h00FC, 0, 0, "R3 based BP wide");
    req(0, 1, 0, 1, 0, 0, 0, 0, "R7 BP indirect uses SS");
    req(0, 1, 0, 0, 0, 0, 0, 0, "R7 BX indirect uses DS");
    req(0, 2, 0, 1, 1, 0, 0, 0, "R7 index only uses DS");
    req(0, 4, 1, 1, 0, 16'h0100, 0, 0, "R2 indexed SI");
    req(0, 5, 0, 1, 1, 16'h0080, 0, 0, "R2 based-indexed BP DI");
    req(0, 6, 1, 0, 0, 16'h4321, 0, 0, "R2 reserved mode is direct");
    req(0, 5, 0, 1, 0, 4, 1, 0, "R8 data override ES");
    req(0, 0, 1, 0, 0, 16'h0010, 1, 1, "R8 data override CS");

    reg_bx = 16'hFFFF; reg_si = 16'h0002;
    req(0, 5, 0, 0, 0, 16'h0001, 0, 0, "R2 offset wrap");
    load_seg(3, 16'hFFFF, "R9 load DS high");
    req(0, 0, 1, 0, 0, 16'hFFFF, 0, 0, "R1 physical wrap");

    seg_we = 1; seg_sel = 2'd3; seg_wdata = 16'h0400;
    req(0, 0, 1, 0, 0, 16'h0008, 0, 0, "R9 same-edge load uses old");
    req(0, 0, 1, 0, 0, 16'h0008, 0, 0, "R9 later request uses new");
    go("R10 idle hold");
    go("R10 idle hold 2");

    for (int k = 0; k < 300; k++) begin
      reg_ip = 16'($urandom); reg_sp = 16'($urandom); reg_bx = 16'($urandom);
      reg_bp = 16'($urandom); reg_si = 16'($urandom); reg_di = 16'($urandom);
      seg_we = 1'($urandom); seg_sel = 2'($urandom); seg_wdata = 16'($urandom);
      if ($urandom % 4 != 0)
        req(int'($urandom % 4), int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom % 65536), 1'($urandom), int'($urandom % 4), "R1 R2 R7 R8 mixed");
      else
        go("R10 mixed idle");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule